// File: doc/BRIEF.md
# Half-Rate 128-Tap FIR Decimator

This block filters a stream of signed samples with a 128-tap FIR and emits one result for every two samples it accepts. The filter halves the sample rate. Each tap weight is a signed Q1.31 value, so 0x80000000 means -1 and 0x7FFFFFFF means 1 - 2^-31. A set of weights that adds up to one gives unity gain in the passband. The weights come from one of two sources, chosen by a 3-bit select:

- A built-in preset, which is a 64-sample running average.
- An external coefficient store. The block reads it one tap at a time through an index output and a coefficient input.

Tap weights that are not needed are set to zero, so a shorter filter needs no special handling.

A single multiply-accumulate unit does the arithmetic. It walks the taps from the oldest sample (h127) to the newest (h0), one tap per clock, and starts on every second accepted sample. The accumulated sum is scaled back by 2^31, rounded half-up and saturated to the sample width. A bypass input turns off both the filtering and the rate halving, so each input sample is copied to the output on the next clock. A synchronous restart clears the sample history and the decimation phase.

Top module: `fir128_decim`

## Requirements
- R1: While reset is active, and after it is released until the first result, `out_valid` is low and `out_data` is zero.
- R2: With bypass low, exactly one result is produced for every two accepted samples: on the 2nd, 4th, 6th, … sample counted since reset or restart. `out_valid` pulses high for one cycle, 128 clock edges after the edge that accepted the even-numbered sample.
- R3: A result equals `sat(floor((sum over k=0..127 of h[k]*x[n-k] + 2^30) / 2^31))`. Here x[n] is the newest sample, and history positions that were never written count as zero.
- R4: Coefficients are signed Q1.31. The preset weights are h[k] = 2^25 for k < 64 and 0 for k >= 64. This set sums to exactly 2^31, so a constant input comes out unchanged once 64 samples of history are present.
- R5: When `coef_sel` = 3'b111 at the start of a result, the weights come from `prog_coef`. During the computation, `prog_idx` counts down by one each clock, from 127 to 0. `prog_coef` must present h[`prog_idx`] in the same cycle.
- R6: Any `coef_sel` value other than 3'b111, including 3'b000, selects the preset weights.
- R7: A result above 2^(W-1)-1 is clamped to 2^(W-1)-1, and a result below -2^(W-1) is clamped to -2^(W-1), where W is the sample width.
- R8: A `restart` pulse zeroes the whole sample history, sets the decimation phase to 0 and aborts any result in progress.
- R9: While `bypass` is high, every valid sample appears on `out_data` with `out_valid` high one edge later. The sample is not stored in the history and does not advance the phase.
- R10: After a sample starts a result, at most one more sample may be offered before that result is delivered. `bypass` only changes while no result is in progress.
- R11: Tap positions whose weight is zero contribute nothing, so a filter with fewer than 128 non-zero taps gives the same result as the shorter filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous clear of history and phase |
| bypass | input | 1 | Pass samples straight through, no filtering or decimation |
| coef_sel | input | 3 | 3'b111 selects the external weights; any other value selects the preset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DW | Signed input sample |
| prog_idx | output | 7 | Tap index being fetched from the external store |
| prog_coef | input | 32 | Q1.31 weight for tap `prog_idx`, same cycle |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | DW | Signed filtered (or bypassed) sample |

## Verification
The sample history, its write pointer, the decimation phase and the tap walk are all internal, so errors in them must be caught at the ports.

- A history slot left stale or mis-addressed changes the value of a result. This shows up on the first result after the bad slot comes into use, which can be up to 64 sample pairs later. For that reason the bench drives more than 128 samples with distinct weights across the full tap range.
- A wrong phase bit makes results appear after odd-numbered samples. This is caught on the very next pair.
- A wrong tap count moves the `out_valid` pulse away from its 128-edge position.
- Mistakes in rounding or clamping only appear with near-full-scale inputs against large weights, so directed cases drive both rails.

// File: rtl/fir128_decim.sv
module fir128_decim #(
  parameter int DW = 24,
  parameter int CW = 32,
  parameter int TAPS = 128,
  parameter int PRESET_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 bypass,
  input  logic [2:0]           coef_sel,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic [$clog2(TAPS)-1:0] prog_idx,
  input  logic signed [CW-1:0] prog_coef,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int IW = $clog2(TAPS);
  localparam int PW = DW + CW;
  localparam int AW = DW + CW + IW;
  localparam int QW = AW - CW + 1;
  localparam int PRE_N = 1 << PRESET_LOG2;
  localparam logic signed [CW-1:0] PRE_C = CW'(1) << (CW - 1 - PRESET_LOG2);
  localparam logic signed [AW-1:0] HALF = AW'(1) << (CW - 2);
  localparam logic [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] hist [TAPS];
  logic [IW-1:0] wp, base, k;
  logic phase, busy, prog_q;
  logic signed [AW-1:0] acc;

  wire take = in_valid && !bypass && !restart;
  wire signed [CW-1:0] coef = prog_q ? prog_coef : ((int'(k) < PRE_N) ? PRE_C : '0);
  wire signed [DW-1:0] xs = hist[base - k];
  wire signed [PW-1:0] prod = xs * coef;
  wire signed [AW-1:0] acc_nx = acc + AW'(prod);
  wire signed [AW-1:0] rnd = acc_nx + HALF;
  wire [QW-1:0] q = rnd[AW-1:CW-1];
  wire fits = (&q[QW-1:DW-1]) | ~(|q[QW-1:DW-1]);
  wire [DW-1:0] ydat = fits ? q[DW-1:0] : (q[QW-1] ? YMIN : YMAX);

  assign prog_idx = k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
    end else if (restart) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
    end else if (take) begin
      hist[wp] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      base <= '0;
      k <= '0;
      phase <= 1'b0;
      busy <= 1'b0;
      prog_q <= 1'b0;
      acc <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
    end else if (restart) begin
      wp <= '0;
      phase <= 1'b0;
      busy <= 1'b0;
      acc <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        acc <= acc_nx;
        k <= k - 1'b1;
        if (k == '0) begin
          busy <= 1'b0;
          out_valid <= 1'b1;
          out_data <= ydat;
        end
      end
      if (take) begin
        wp <= wp + 1'b1;
        phase <= ~phase;
        if (phase) begin
          busy <= 1'b1;
          base <= wp;
          k <= IW'(TAPS - 1);
          acc <= '0;
          prog_q <= (coef_sel == 3'b111);
        end
      end
      if (bypass && in_valid) begin
        out_valid <= 1'b1;
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/fir128_decim_chk.sv
module fir128_decim_chk #(
  parameter int DW = 24,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          bypass,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          busy,
  input logic          phase,
  input logic [IW-1:0] prog_idx
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R9
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && in_valid && !restart && !busy |=> out_valid && out_data == $past(in_data));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass && out_valid |=> !out_valid || bypass);

  // R10
  pacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && phase |-> !(in_valid && !bypass && !restart));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !busy && !out_valid && !phase);

  // R5
  tap_walk_chk: assert property (@(posedge clk) disable iff (!rst_n || restart)
    busy && $past(busy) |-> prog_idx == $past(prog_idx) - 1'b1);
endmodule

bind fir128_decim fir128_decim_chk #(.DW(DW), .IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .bypass(bypass),
  .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
  .out_data(out_data), .busy(busy), .phase(phase), .prog_idx(prog_idx)
);

// File: tb/test_fir128_decim.sv
module test_fir128_decim;
  localparam int DW = 24;
  logic clk = 0, rst_n = 0, restart = 0, bypass = 0, in_valid = 0;
  logic [2:0] coef_sel = 3'b000;
  logic signed [DW-1:0] in_data = '0;
  logic [6:0] prog_idx;
  logic signed [31:0] prog_coef;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  logic signed [31:0] pmem [128];
  int xs[$];
  int oq[$];
  longint ot[$];
  longint cyc = 0;
  int errors = 0, checks = 0;

  assign prog_coef = pmem[prog_idx];

  fir128_decim i_fir128_decim (
    .clk(clk), .rst_n(rst_n), .restart(restart), .bypass(bypass),
    .coef_sel(coef_sel), .in_valid(in_valid), .in_data(in_data),
    .prog_idx(prog_idx), .prog_coef(prog_coef),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (out_valid) begin oq.push_back(int'(out_data)); ot.push_back(cyc); end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint coef_of(input int k);
    if (coef_sel == 3'b111) return longint'(pmem[k]);
    return (k < 64) ? (64'sd1 <<< 25) : 64'sd0;
  endfunction

  function automatic longint expect_y();
    longint acc = 0, y;
    int n = xs.size() - 1;
    for (int k = 0; k < 128; k++)
      if (n - k >= 0) acc += coef_of(k) * longint'(xs[n - k]);
    y = (acc + (64'sd1 <<< 30)) >>> 31;
    if (y > 8388607) y = 8388607;
    if (y < -8388608) y = -8388608;
    return y;
  endfunction

  task automatic send(input int x, output longint c0);
    @(negedge clk);
    in_valid = 1; in_data = DW'(x);
    @(negedge clk);
    in_valid = 0;
    c0 = cyc;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    xs.delete();
  endtask

  task automatic send_pair(input int a, input int b, input string req, output longint y);
    longint c0;
    oq.delete(); ot.delete();
    send(a, c0); xs.push_back(a);
    repeat (68) @(negedge clk);
    send(b, c0); xs.push_back(b);
    y = expect_y();
    repeat (130) @(negedge clk);
    chk(oq.size() == 1 && ot[0] == c0 + 128, {req, " R2 one pulse at +128"},
        (oq.size() == 1) ? ot[0] - c0 : -oq.size(), 128);
    if (oq.size() == 1) chk(oq[0] == y, req, oq[0], y);
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1 valid in reset", out_valid, 0);
    chk(out_data == 0, "R1 data in reset", out_data, 0);
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 valid after reset", out_valid, 0);
    chk(out_data == 0, "R1 data after reset", out_data, 0);
  endtask

  task automatic t_preset_dc();
    longint y;
    coef_sel = 3'b000;
    do_restart();
    for (int i = 0; i < 40; i++) send_pair(1000, 1000, "R4 preset DC", y);
    chk(y == 1000, "R4 unity gain", y, 1000);
    for (int i = 0; i < 6; i++) send_pair(i * 3717 - 9000, -i * 511, "R3 preset mixed", y);
  endtask

  task automatic t_prog_taps();
    longint y;
    for (int i = 0; i < 128; i++) pmem[i] = 0;
    pmem[0] = 32'h7FFFFFFF;
    pmem[3] = 32'hC0000000;
    pmem[64] = 32'h10000000;
    pmem[127] = 32'h20000000;
    coef_sel = 3'b111;
    do_restart();
    for (int i = 0; i < 70; i++) send_pair(i * 1231 - 40000, 55555 - i * 977, "R5 R11 programmed taps", y);
  endtask

  task automatic t_saturate();
    longint y;
    for (int i = 0; i < 128; i++) pmem[i] = 0;
    for (int i = 0; i < 4; i++) pmem[i] = 32'h7FFFFFFF;
    coef_sel = 3'b111;
    do_restart();
    send_pair(8388607, 8388607, "R7 high rail", y);
    send_pair(8388607, 8388607, "R7 high rail", y);
    chk(y == 8388607, "R7 clamp high", y, 8388607);
    do_restart();
    send_pair(-8388608, -8388608, "R7 low rail", y);
    send_pair(-8388608, -8388608, "R7 low rail", y);
    chk(y == -8388608, "R7 clamp low", y, -8388608);
  endtask

  task automatic t_other_sel();
    longint y;
    for (int i = 0; i < 128; i++) pmem[i] = 32'h40000000;
    do_restart();
    coef_sel = 3'b010;
    for (int i = 0; i < 36; i++) send_pair(2048, 2048, "R6 select 010 preset", y);
    chk(y == 2048, "R6 preset gain", y, 2048);
  endtask

  task automatic t_restart();
    longint y, c0;
    coef_sel = 3'b000;
    for (int i = 0; i < 5; i++) send_pair(50000, 60000, "R8 fill", y);
    send(777, c0);
    do_restart();
    send_pair(640, 1280, "R8 after restart", y);
    chk(y == 30, "R8 history zeroed", y, 30);
  endtask

  task automatic t_bypass();
    longint y, c0;
    bypass = 1;
    for (int i = 0; i < 3; i++) begin
      send(-1234 + i * 99991, c0);
      chk(out_valid == 1 && out_data == DW'(-1234 + i * 99991), "R9 bypass copy",
          out_data, -1234 + i * 99991);
      @(negedge clk);
      chk(out_valid == 0, "R9 bypass single", out_valid, 0);
    end
    bypass = 0;
    send_pair(640, 1280, "R9 history untouched", y);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) pmem[i] = 0;
    t_reset();
    t_preset_dc();
    t_prog_taps();
    t_saturate();
    t_other_sel();
    t_restart();
    t_bypass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule